// File: doc/BRIEF.md
# Serial Receive Holding Buffer with Status Flags

This block sits between the shift register of a serial receiver and a CPU register port. Each time the receiver finishes a byte, it pulses a completion strobe together with that byte. The block then copies the byte into a holding data register and raises a data-full flag. If a second byte finishes before software has released the first, the block keeps the old byte, discards the new one and raises an overrun flag. While the overrun flag is set, reception stops, and in clock-synchronous operation transmission stops as well.

Software clears either flag with a two-step handshake. It first reads the status register while the flag reads as 1, and then it writes 0 to that flag's bit. A write of 0 without that earlier read does nothing, and a write of 1 never does anything. Reset or entry into standby clears both flags. Turning the receive enable off leaves the flags and the data register as they were.

Top module: `rx_hold_buf`

## Requirements
- R1: After reset, and on the clock edge after `standby` is high, `rdr_full` and `overrun` are 0. Standby also discards any pending read-as-1 record.
- R2: A completion strobe with `rx_en`=1, `frame_err`=0, `overrun`=0 and `rdr_full`=0 loads `frame_byte` into `rx_data` and sets `rdr_full`. Both are visible after the next clock edge.
- R3: A completion strobe that would be accepted while `rdr_full` is 1, and that is not paired with a valid full-flag clear, sets `overrun` and leaves `rx_data` unchanged. No other event sets `overrun`.
- R4: While `overrun` is 1, completion strobes are discarded and `rx_inhibit` is 1. `tx_inhibit` is 1 only when `overrun` and `sync_mode` are both 1.
- R5: `rdr_full` clears on a write to the status address (1) with bit 0 = 0, but only if a status read since the flag was last cleared returned bit 0 = 1. Otherwise the write leaves the flag unchanged.
- R6: `overrun` follows the same read-as-1-then-write-0 rule using status bit 1.
- R7: Writing 1 to status bit 0 or bit 1 has no effect on the flags, and it does not use up an earlier read-as-1 record.
- R8: With `rx_en`=0, completion strobes are ignored and `rdr_full`, `overrun` and `rx_data` keep their values.
- R9: A completion strobe with `frame_err`=1 changes neither `rdr_full` nor `rx_data`.
- R10: When a valid full-flag clear and an accepted completion strobe occur in the same cycle, the new byte is loaded, `rdr_full` stays 1 and `overrun` stays 0.
- R11: `reg_rdata` returns `rx_data` at address 0 and the status word at address 1 (bit 0 = full, bit 1 = overrun, other bits 0), and 0 at any other address. Reading address 0 does not arm any flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Standby entry; clears the flags |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 selects clock-synchronous operation |
| frame_done | input | 1 | Byte-complete strobe from the shift register |
| frame_err | input | 1 | The completed byte has a framing or parity error |
| frame_byte | input | DW | Byte assembled by the shift register |
| reg_addr | input | AW | Register address |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read enable |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| rx_data | output | DW | Holding data register |
| rdr_full | output | 1 | Receive data full flag |
| overrun | output | 1 | Overrun error flag |
| rx_inhibit | output | 1 | Stops the receiver |
| tx_inhibit | output | 1 | Stops the transmitter in synchronous mode |

## Verification
The checker applies several rules on every cycle:
- standby clears both flags;
- a byte that arrives while the buffer is full raises the overrun flag and keeps the held byte;
- the data register stays frozen while the overrun flag is set;
- a write of 0 that was not preceded by a read leaves the full flag set;
- with the receiver disabled, nothing changes.

Some behaviour shows up only across the bench's scenarios: the full read-then-clear handshake, the rule that a write of 1 does not use up an armed clear, the same-cycle clear-and-load case, the read data map, and the way the transmit-inhibit output follows the synchronous-mode input.

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int DW        = 8,
  parameter int AW        = 2,
  parameter int DATA_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int FULL_BIT  = 0,
  parameter int OVR_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          rx_en,
  input  logic          sync_mode,
  input  logic          frame_done,
  input  logic          frame_err,
  input  logic [DW-1:0] frame_byte,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] rx_data,
  output logic          rdr_full,
  output logic          overrun,
  output logic          rx_inhibit,
  output logic          tx_inhibit
);

  logic full_q, ovr_q, arm_full, arm_ovr;
  logic [DW-1:0] data_q;

  logic stat_sel, rd_stat, wr_stat, clr_full, clr_ovr, take, full_after;
  assign stat_sel   = (reg_addr == AW'(STAT_ADDR));
  assign rd_stat    = reg_re && stat_sel;
  assign wr_stat    = reg_we && stat_sel;
  assign clr_full   = wr_stat && !reg_wdata[FULL_BIT] && arm_full;
  assign clr_ovr    = wr_stat && !reg_wdata[OVR_BIT] && arm_ovr;
  assign take       = frame_done && rx_en && !frame_err && !ovr_q;
  assign full_after = full_q && !clr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      arm_full <= 1'b0;
      arm_ovr  <= 1'b0;
      data_q   <= '0;
    end else if (standby) begin
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      arm_full <= 1'b0;
      arm_ovr  <= 1'b0;
    end else begin
      if (clr_full)                arm_full <= 1'b0;
      else if (rd_stat && full_q)  arm_full <= 1'b1;
      if (clr_ovr)                 arm_ovr  <= 1'b0;
      else if (rd_stat && ovr_q)   arm_ovr  <= 1'b1;

      if (take && full_after)      ovr_q <= 1'b1;
      else if (clr_ovr)            ovr_q <= 1'b0;

      if (take && !full_after) begin
        full_q <= 1'b1;
        data_q <= frame_byte;
      end else if (clr_full) begin
        full_q <= 1'b0;
      end
    end
  end

  logic [DW-1:0] stat_word;
  always_comb begin
    stat_word           = '0;
    stat_word[FULL_BIT] = full_q;
    stat_word[OVR_BIT]  = ovr_q;
  end

  always_comb begin
    if (reg_addr == AW'(DATA_ADDR))      reg_rdata = data_q;
    else if (stat_sel)                   reg_rdata = stat_word;
    else                                 reg_rdata = '0;
  end

  assign rx_data    = data_q;
  assign rdr_full   = full_q;
  assign overrun    = ovr_q;
  assign rx_inhibit = ovr_q;
  assign tx_inhibit = ovr_q && sync_mode;

endmodule

// File: rtl/rx_hold_buf_chk.sv
module rx_hold_buf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          rx_en,
  input logic          frame_done,
  input logic          frame_err,
  input logic          wr_stat,
  input logic          wbit_full,
  input logic          arm_full,
  input logic [DW-1:0] rx_data,
  input logic          rdr_full,
  input logic          overrun
);

  p_standby_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!rdr_full && !overrun));

  p_overrun_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_full && frame_done && rx_en && !frame_err && !overrun && !wr_stat && !standby)
      |=> (overrun && $stable(rx_data)));

  p_overrun_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!overrun && !(frame_done && rdr_full)) |=> !overrun);

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> $stable(rx_data));

  p_no_arm_no_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_full && wr_stat && !wbit_full && !arm_full && !standby) |=> rdr_full);

  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !wr_stat && !standby)
      |=> ($stable(rdr_full) && $stable(overrun) && $stable(rx_data)));

endmodule

bind rx_hold_buf rx_hold_buf_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby   (standby),
  .rx_en     (rx_en),
  .frame_done(frame_done),
  .frame_err (frame_err),
  .wr_stat   (wr_stat),
  .wbit_full (reg_wdata[FULL_BIT]),
  .arm_full  (arm_full),
  .rx_data   (rx_data),
  .rdr_full  (rdr_full),
  .overrun   (overrun)
);

// File: tb/rx_hold_buf_test.sv
module rx_hold_buf_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0, rx_en = 1'b1, sync_mode = 1'b0;
  logic       frame_done = 1'b0, frame_err = 1'b0;
  logic [7:0] frame_byte = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, rx_data;
  logic       rdr_full, overrun, rx_inhibit, tx_inhibit;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_hold_buf uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .rx_en(rx_en),
    .sync_mode(sync_mode), .frame_done(frame_done), .frame_err(frame_err),
    .frame_byte(frame_byte), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_data(rx_data), .rdr_full(rdr_full), .overrun(overrun),
    .rx_inhibit(rx_inhibit), .tx_inhibit(tx_inhibit)
  );

  // op: 0 idle, 1 frame, 2 status read, 3 status write
  // fields: op[21:20] val[19:12] en[11] ferr[10] full[9] ovr[8] data[7:0]
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5},  // R2 load
    {2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5},  // R5 write 0 without read
    {2'd1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5},  // R3 overrun keeps data
    {2'd1, 8'h77, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5},  // R4 frozen
    {2'd2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5},  // read arms both
    {2'd3, 8'h03, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5},  // R7 write ones
    {2'd3, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5},  // R5 R6 clear
    {2'd1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},  // R8 disabled
    {2'd1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5},  // R9 error frame
    {2'd1, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A},  // R2 reload
    {2'd2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A},  // arm full
    {2'd3, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A}   // R5 clear bit0 only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    frame_done = 1'b0; frame_err = 1'b0; reg_we = 1'b0; reg_re = 1'b0;
    standby = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle_inputs();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset full", rdr_full, 0);
    check("R1 reset ovr", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      rx_en = v[11];
      case (v[21:20])
        2'd1: begin frame_done = 1'b1; frame_byte = v[19:12]; frame_err = v[10]; end
        2'd2: begin reg_re = 1'b1; reg_addr = 2'd1; end
        2'd3: begin reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = v[19:12]; end
        default: ;
      endcase
      step();
      check($sformatf("R2-vec%0d full", i), rdr_full, v[9]);
      check($sformatf("R3-vec%0d ovr", i), overrun, v[8]);
      check($sformatf("R3-vec%0d data", i), rx_data, v[7:0]);
    end
    rx_en = 1'b1;

    // R4: inhibit outputs during overrun, by mode
    frame_done = 1'b1; frame_byte = 8'h01; step();
    frame_done = 1'b1; frame_byte = 8'h02; step();
    check("R4 rx_inhibit", rx_inhibit, 1);
    check("R4 tx_inhibit async", tx_inhibit, 0);
    sync_mode = 1'b1; #1;
    check("R4 tx_inhibit sync", tx_inhibit, 1);
    check("R4 data kept", rx_data, 8'h01);
    sync_mode = 1'b0;

    // R11: read map while armed state is observable
    reg_re = 1'b1; reg_addr = 2'd1; #1;
    check("R11 status word", reg_rdata, 8'h03);
    step();
    reg_addr = 2'd0; reg_re = 1'b1; #1;
    check("R11 data read", reg_rdata, 8'h01);
    reg_addr = 2'd3; #1;
    check("R11 unmapped", reg_rdata, 8'h00);
    step();

    // R1: standby clears flags and arms
    standby = 1'b1; step();
    check("R1 standby full", rdr_full, 0);
    check("R1 standby ovr", overrun, 0);
    check("R1 standby data kept", rx_data, 8'h01);

    // R10: same-cycle clear and load
    frame_done = 1'b1; frame_byte = 8'h44; step();
    reg_re = 1'b1; reg_addr = 2'd1; step();
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
    frame_done = 1'b1; frame_byte = 8'h99; step();
    check("R10 full", rdr_full, 1);
    check("R10 ovr", overrun, 0);
    check("R10 data", rx_data, 8'h99);

    // R11: data read arms nothing
    reg_re = 1'b1; reg_addr = 2'd0; step();
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00; step();
    check("R11 no arm from data read", rdr_full, 1);

    // R6: overrun clears alone, frame during clear still discarded
    frame_done = 1'b1; frame_byte = 8'hEE; step();
    check("R6 ovr set", overrun, 1);
    reg_re = 1'b1; reg_addr = 2'd1; step();
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
    frame_done = 1'b1; frame_byte = 8'h66; step();
    check("R6 ovr cleared", overrun, 0);
    check("R6 full kept", rdr_full, 1);
    check("R6 data kept", rx_data, 8'h99);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R1 reset full", rdr_full, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule